// File: doc/BRIEF.md
# Frame Skew Meter

This block measures how late the frame marker of one chosen serial stream arrives relative to the reference frame pulse. Twenty-four active-low evaluation lines come in. A select field picks one of them. Software arms a measurement through a start bit. The block then times one complete frame that opens on a reference pulse. It reports the delay to the first low sample on the chosen line, counted in half master-clock periods, together with a completion flag.

The start handshake is edge-triggered. The start bit must stay low across a whole frame, and then rise. The next reference pulse opens the measured frame, and the completion flag rises one frame after that. Dropping the start bit clears the flag and re-arms the sequence. The result register keeps its value until the next measurement completes.

Top module: `frame_skew_meter`

## Requirements
- R1: The 5-bit select value 0..23 chooses evaluation line `eval_n[sel]`; any select value of 24 or more measures line 0.
- R2: A rising edge of `meas_start` launches a measurement only if `meas_start` was sampled low at two consecutive reference pulses before that edge; any other rising edge is ignored, and `meas_done` stays 0.
- R3: After a launch, the next reference pulse (P0) opens the window. `meas_done` rises in the clock cycle that follows the next reference pulse (P1), which is exactly one frame later.
- R4: `meas_result` is the distance in half master-clock periods from the rising clock edge that samples P0 to the first clock edge of either polarity at which the selected line is low. Even values come from rising-edge samples and odd values from falling-edge samples. A rising-edge sample taken at P1 is not part of the window.
- R5: If the selected line is never low inside the window, or the first low sample lies 1024 or more half periods after P0, the result is 1023.
- R6: `meas_done` falls in the cycle after `meas_start` is sampled low, and `meas_result` keeps its value.
- R7: Low pulses on evaluation lines other than the selected one have no effect on the result.
- R8: While `meas_start` stays high after completion, `meas_done` stays 1 and no further measurement starts. A new one needs another full frame with `meas_start` low.
- R9: During reset, `meas_done` is 0 and `meas_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; rising and falling edges both sample the selected line |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_frame | input | 1 | Reference frame pulse, high for one clock cycle per frame |
| eval_n | input | 24 | Active-low frame evaluation lines |
| meas_start | input | 1 | Start bit; a qualified rising edge launches a measurement |
| eval_sel | input | 5 | Evaluation line select |
| meas_result | output | 10 | Measured offset in half clock periods |
| meas_done | output | 1 | Completion flag |

## Verification
The bench drives narrow low pulses that cover a single rising or falling edge, so that odd offsets are told apart from even ones. It also drives a wide pulse to show that only the first low sample counts. Pulses just under, at and beyond 1023 half periods, and a frame with no pulse at all, separate true counts from saturation. A decoy pulse on a neighbouring line and out-of-range select codes show that the select decoding and the fallback to line 0 are correct. A rising edge of the start bit after too short a low phase shows that an unqualified start is ignored.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_MEAS  = 2'd2,
    ST_DONE  = 2'd3
  } fsk_state_e;
endpackage

// File: rtl/fsk_tap_sel.sv
// Picks one evaluation line and samples it on the falling clock edge.
module fsk_tap_sel #(
  parameter int unsigned NUM_IN = 24,
  parameter int unsigned SEL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] eval_n,
  input  logic [SEL_W-1:0]  sel,
  output logic              tap_now,
  output logic              tap_fall
);
  logic [NUM_IN-1:0] hit;
  logic              sel_ok;

  assign sel_ok = (int'(sel) < NUM_IN);

  generate
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_hit
      if (gi == 0) begin : g_zero
        assign hit[gi] = (int'(sel) == gi) || !sel_ok;
      end else begin : g_other
        assign hit[gi] = (int'(sel) == gi);
      end
    end
  endgenerate

  // Active-low: line reads low only if the hit line is low.
  assign tap_now = ~|(hit & ~eval_n);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) tap_fall <= 1'b1;
    else        tap_fall <= tap_now;
  end
endmodule

// File: rtl/fsk_start_qual.sv
// Qualifies the start edge: it needs low at two consecutive frame pulses.
module fsk_start_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fp,
  output logic launch
);
  logic start_q, low_mark, primed;
  logic start_q_n, low_mark_n, primed_n;

  always_comb begin
    start_q_n  = start;
    low_mark_n = low_mark;
    primed_n   = primed;
    if (start) begin
      low_mark_n = 1'b0;
      primed_n   = 1'b0;
    end else if (fp) begin
      low_mark_n = 1'b1;
      primed_n   = primed | low_mark;
    end
  end

  assign launch = start && !start_q && primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      low_mark <= 1'b0;
      primed   <= 1'b0;
    end else begin
      start_q  <= start_q_n;
      low_mark <= low_mark_n;
      primed   <= primed_n;
    end
  end
endmodule

// File: rtl/fsk_span_cnt.sv
// Counts clock cycles inside the window and captures the first low sample.
module fsk_span_cnt #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open,
  input  logic             run,
  input  logic             close,
  input  logic             tap_now,
  input  logic             tap_fall,
  output logic [RES_W-1:0] final_val
);
  localparam int unsigned     W1   = RES_W + 1;
  localparam logic [RES_W-1:0] MAXV = '1;

  logic [RES_W-1:0] cyc, cyc_n;
  logic [RES_W-1:0] val, val_n;
  logic             found, found_n;
  logic [W1-1:0]    even_w, odd_w, cand_w;
  logic             cand_hit;
  logic [RES_W-1:0] cand_val;

  always_comb begin
    even_w   = {cyc, 1'b0};
    odd_w    = even_w - {{RES_W{1'b0}}, 1'b1};
    cand_hit = 1'b0;
    cand_w   = even_w;
    if (run && !found) begin
      if (!tap_fall) begin
        cand_hit = 1'b1;
        cand_w   = odd_w;
      end else if (!close && !tap_now) begin
        cand_hit = 1'b1;
        cand_w   = even_w;
      end
    end
    cand_val = (cand_w > {1'b0, MAXV}) ? MAXV : cand_w[RES_W-1:0];
  end

  always_comb begin
    cyc_n   = cyc;
    val_n   = val;
    found_n = found;
    if (open) begin
      cyc_n   = {{(RES_W-1){1'b0}}, 1'b1};
      found_n = !tap_now;
      val_n   = '0;
    end else if (run) begin
      if (cyc != MAXV) cyc_n = cyc + 1'b1;
      if (cand_hit) begin
        found_n = 1'b1;
        val_n   = cand_val;
      end
    end
  end

  assign final_val = found ? val : (cand_hit ? cand_val : MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc   <= '0;
      val   <= '0;
      found <= 1'b0;
    end else begin
      cyc   <= cyc_n;
      val   <= val_n;
      found <= found_n;
    end
  end
endmodule

// File: rtl/frame_skew_meter.sv
module frame_skew_meter #(
  parameter int unsigned NUM_IN = 24,
  parameter int unsigned SEL_W  = $clog2(NUM_IN),
  parameter int unsigned RES_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_frame,
  input  logic [NUM_IN-1:0] eval_n,
  input  logic              meas_start,
  input  logic [SEL_W-1:0]  eval_sel,
  output logic [RES_W-1:0]  meas_result,
  output logic              meas_done
);
  import fsk_pkg::*;

  fsk_state_e       state, state_n;
  logic             done_n;
  logic [RES_W-1:0] result_n;
  logic             tap_now, tap_fall, launch;
  logic             open, run, close;
  logic [RES_W-1:0] final_val;

  fsk_tap_sel #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_tap (
    .clk(clk), .rst_n(rst_n), .eval_n(eval_n), .sel(eval_sel),
    .tap_now(tap_now), .tap_fall(tap_fall)
  );

  fsk_start_qual u_qual (
    .clk(clk), .rst_n(rst_n), .start(meas_start), .fp(ref_frame),
    .launch(launch)
  );

  assign open  = (state == ST_ARMED) && meas_start && ref_frame;
  assign run   = (state == ST_MEAS) && meas_start;
  assign close = run && ref_frame;

  fsk_span_cnt #(.RES_W(RES_W)) u_span (
    .clk(clk), .rst_n(rst_n), .open(open), .run(run), .close(close),
    .tap_now(tap_now), .tap_fall(tap_fall), .final_val(final_val)
  );

  always_comb begin
    state_n  = state;
    done_n   = meas_done;
    result_n = meas_result;
    unique case (state)
      ST_IDLE:  if (launch) state_n = ST_ARMED;
      ST_ARMED: begin
        if (!meas_start)    state_n = ST_IDLE;
        else if (ref_frame) state_n = ST_MEAS;
      end
      ST_MEAS: begin
        if (!meas_start) state_n = ST_IDLE;
        else if (close) begin
          state_n  = ST_DONE;
          done_n   = 1'b1;
          result_n = final_val;
        end
      end
      ST_DONE: begin
        if (!meas_start) begin
          state_n = ST_IDLE;
          done_n  = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      meas_done   <= 1'b0;
      meas_result <= '0;
    end else begin
      state       <= state_n;
      meas_done   <= done_n;
      meas_result <= result_n;
    end
  end
endmodule

// File: rtl/fsk_checker.sv
module fsk_checker #(
  parameter int unsigned RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_frame,
  input logic             meas_start,
  input logic [RES_W-1:0] meas_result,
  input logic             meas_done
);
  p_done_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && !meas_start) |=> !meas_done);

  p_done_after_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_done) |-> $past(ref_frame));

  p_done_under_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_done) |-> $past(meas_start));

  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(meas_done) |-> $stable(meas_result));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && meas_start) |=> meas_done);
endmodule

bind frame_skew_meter fsk_checker #(.RES_W(RES_W)) i_fsk_checker (
  .clk(clk), .rst_n(rst_n), .ref_frame(ref_frame), .meas_start(meas_start),
  .meas_result(meas_result), .meas_done(meas_done)
);

// File: tb/test_frame_skew_meter.sv
`timescale 1ns/1ps
module test_frame_skew_meter;
  localparam int NUM_IN = 24;
  localparam int SEL_W  = 5;
  localparam int RES_W  = 10;
  localparam int FRAME  = 600;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ref_frame = 1'b0;
  logic [NUM_IN-1:0] eval_n = '1;
  logic              meas_start = 1'b0;
  logic [SEL_W-1:0]  eval_sel = '0;
  logic [RES_W-1:0]  meas_result;
  logic              meas_done;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_q[$];
  bit done_prev = 1'b0;
  bit fp_prev   = 1'b0;

  always #5 clk = ~clk;

  frame_skew_meter i_frame_skew_meter (
    .clk(clk), .rst_n(rst_n), .ref_frame(ref_frame), .eval_n(eval_n),
    .meas_start(meas_start), .eval_sel(eval_sel),
    .meas_result(meas_result), .meas_done(meas_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference frame pulse: one cycle high every FRAME cycles.
  initial begin
    int cnt = 0;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #2;
      ref_frame = (cnt == FRAME - 1);
      cnt = (cnt == FRAME - 1) ? 0 : cnt + 1;
    end
  end

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && meas_done && !done_prev) begin
        check(fp_prev, "R3 done one cycle after frame pulse", int'(fp_prev), 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected completion", 1, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(meas_result == RES_W'(e), "R4/R5 result", int'(meas_result), e);
        end
      end
      done_prev = meas_done;
      fp_prev   = ref_frame;
    end
  end

  task automatic wait_fp(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!ref_frame) @(posedge clk);
    end
  endtask

  // line<0: no pulse; dline<0: no decoy. Decoy must come before the main pulse.
  task automatic do_meas(input int sel, input int line, input int h, input int width,
                         input int dline, input int dh, input int exp);
    eval_sel = SEL_W'(sel);
    wait_fp(2);
    @(posedge clk);
    #2 meas_start = 1'b1;
    exp_q.push_back(exp);
    wait_fp(1);
    if (dline >= 0) begin
      #(5 * dh - 2) eval_n[dline] = 1'b0;
      #4 eval_n[dline] = 1'b1;
      if (line >= 0) begin
        #(5 * (h - dh) - 4) eval_n[line] = 1'b0;
        #(width) eval_n[line] = 1'b1;
      end
    end else if (line >= 0) begin
      #(5 * h - 2) eval_n[line] = 1'b0;
      #(width) eval_n[line] = 1'b1;
    end
    while (!meas_done) @(negedge clk);
    @(negedge clk);
    meas_start = 1'b0;
    @(negedge clk);
    check(meas_done == 1'b0, "R6 done clears after start low", int'(meas_done), 0);
    check(meas_result == RES_W'(exp), "R6 result held", int'(meas_result), exp);
  endtask

  initial begin
    #3;
    check(meas_done == 1'b0, "R9 reset done", int'(meas_done), 0);
    check(meas_result == '0, "R9 reset result", int'(meas_result), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    do_meas(3, 3, 1, 4, -1, 0, 1);          // R4 odd half period
    do_meas(7, 7, 2, 4, -1, 0, 2);          // R4 even half period
    do_meas(23, 23, 37, 4, -1, 0, 37);      // R1 top select
    do_meas(27, 0, 100, 4, -1, 0, 100);     // R1 out-of-range -> line 0
    do_meas(12, 12, 250, 4, 11, 10, 250);   // R7 decoy on line 11
    do_meas(2, 2, 40, 30, -1, 0, 40);       // R4 wide pulse, first sample

    // R8: start kept high after completion
    eval_sel = SEL_W'(5);
    wait_fp(2);
    @(posedge clk);
    #2 meas_start = 1'b1;
    exp_q.push_back(1022);
    wait_fp(1);
    #(5 * 1022 - 2) eval_n[5] = 1'b0;
    #4 eval_n[5] = 1'b1;
    while (!meas_done) @(negedge clk);
    wait_fp(2);
    @(negedge clk);
    check(meas_done == 1'b1, "R8 done stays while start high", int'(meas_done), 1);
    check(meas_result == 10'd1022, "R8 no second measurement", int'(meas_result), 1022);
    check(exp_q.size() == 0, "R8 no extra completion", exp_q.size(), 0);

    // R2: start low for a few cycles only, then high again
    meas_start = 1'b0;
    repeat (5) @(negedge clk);
    meas_start = 1'b1;
    eval_n[5] = 1'b0;
    wait_fp(3);
    @(negedge clk);
    eval_n[5] = 1'b1;
    check(meas_done == 1'b0, "R2 unqualified start ignored", int'(meas_done), 0);
    check(meas_result == 10'd1022, "R2 result untouched", int'(meas_result), 1022);
    meas_start = 1'b0;

    do_meas(5, 5, 1023, 4, -1, 0, 1023);    // R5 boundary
    do_meas(5, 5, 1100, 4, -1, 0, 1023);    // R5 saturation
    do_meas(9, -1, 0, 0, -1, 0, 1023);      // R5 no pulse

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R3 all results delivered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule